// File: doc/BRIEF.md
# Boot Image Copy Engine

This block runs once after every reset. When reset is released it moves a fixed boot image out of a narrow external ROM into on-chip memory starting at word zero. The processor is kept in a stall for the whole move and is let go only after the final word is in memory, so its first fetch from address zero finds the complete image.

The ROM is read through a plain select-and-address interface. Each read holds one address for a fixed number of clock cycles and samples the data on the last of them. Two strap inputs choose a ROM width of 8 or 16 bits and choose the byte order. The engine gathers two or four consecutive ROM reads into one 32-bit word. Each finished word goes out on a one-cycle write strobe together with its word index. Once the image is in place, a done flag rises and stays high until the next reset.

Top module: `bootcopy_engine`

## Requirements
- R1: In the first cycle after the first clock edge that sees reset low, `rom_cs` is high and `rom_addr` equals `ROM_BASE`. No other request is needed to start the copy.
- R2: While reset is asserted, `cpu_stall` is 1 and `boot_done`, `rom_cs` and `ram_we` are 0.
- R3: Exactly `WORDS` words are written. Their `ram_idx` values run 0, 1, 2 and so on up to `WORDS`-1, each used exactly once and in that order.
- R4: ROM byte addresses start at `ROM_BASE` and step by 1 in 8-bit mode or by 2 in 16-bit mode. Each address is held with `rom_cs` high for exactly `WAIT_CYC` cycles, and `rom_data` is sampled in the last of those cycles.
- R5: With 8-bit width and little-endian order (`strap_big` = 0), the byte read from the lowest address of a group of four lands in `ram_wdata[7:0]` and the highest in `ram_wdata[31:24]`.
- R6: With 8-bit width and big-endian order (`strap_big` = 1), the byte from the lowest address lands in `ram_wdata[31:24]` and the highest in `ram_wdata[7:0]`.
- R7: With 16-bit width (`strap_rom16` = 1), the first half-word of a pair lands in `ram_wdata[15:0]` in little-endian order and in `ram_wdata[31:16]` in big-endian order.
- R8: In 8-bit mode, `rom_data[15:8]` has no effect on the written data.
- R9: The straps are taken from their value during reset. Changing them after reset is released does not change the width, order or addressing of the copy in progress.
- R10: `cpu_stall` stays high through the cycle of the last write. In the next cycle it falls and `boot_done` rises. Counting from the first clock edge with reset low, this happens WORDS·(4 or 2)·WAIT_CYC + 1 edges later.
- R11: Once `boot_done` is high, it stays high until reset, and no further ROM select or RAM write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strap_rom16 | input | 1 | Width strap: 1 = 16-bit ROM, 0 = 8-bit ROM |
| strap_big | input | 1 | Order strap: 1 = big-endian, 0 = little-endian |
| rom_cs | output | 1 | ROM select, high while a read is in progress |
| rom_addr | output | ROM_AW | ROM byte address |
| rom_data | input | 16 | ROM read data (bits 7:0 only in 8-bit mode) |
| ram_we | output | 1 | One-cycle write strobe to internal memory |
| ram_idx | output | $clog2(WORDS) | Word index of the write |
| ram_wdata | output | 32 | Assembled 32-bit word |
| cpu_stall | output | 1 | Holds the processor while the image is copied |
| boot_done | output | 1 | High from release until the next reset |

## Verification
The bench builds the engine with the full 256-word image, `WAIT_CYC` = 3 and a non-zero `ROM_BASE` of 0x4000. The three-cycle dwell makes the per-address hold and the sample point visible on `rom_addr`. The offset base shows that addressing starts from the parameter and not from zero. All four combinations of width and byte order run back to back, each from a fresh reset. In two of them the straps are flipped part way through the copy. The ROM model puts a fixed noise pattern on the unused upper byte in 8-bit mode.

// File: rtl/bootcopy_pkg.sv
package bootcopy_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_COPY,
        PH_FLUSH,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic wide;   // 16-bit ROM
        logic big;    // big-endian lane order
    } strap_t;

    // Place one ROM unit (byte or half-word) into its lane of the word.
    // k is the position of the unit inside its group, 0 = lowest address.
    function automatic logic [31:0] lane_insert(
        input logic [31:0] acc,
        input logic [15:0] unit,
        input logic [1:0]  k,
        input strap_t      s
    );
        logic [31:0] r;
        logic [1:0]  slot;
        r = acc;
        if (s.wide) begin
            slot = s.big ? {1'b0, ~k[0]} : {1'b0, k[0]};
            r[int'(slot) * 16 +: 16] = unit;
        end else begin
            slot = s.big ? (2'd3 - k) : k;
            r[int'(slot) * 8 +: 8] = unit[7:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/bootcopy_rom_seq.sv
module bootcopy_rom_seq
    import bootcopy_pkg::*;
#(
    parameter int unsigned ROM_AW   = 20,
    parameter int unsigned ROM_BASE = 0,
    parameter int unsigned WAIT_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  strap_t            strap,
    output logic              rom_cs,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              unit_stb
);
    localparam int unsigned WCW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [WCW-1:0] WLAST = WCW'(WAIT_CYC - 1);

    logic [WCW-1:0]    wait_q;
    logic [ROM_AW-1:0] addr_q;

    assign rom_cs   = run;
    assign rom_addr = addr_q;
    assign unit_stb = run && (wait_q == WLAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q <= '0;
            addr_q <= ROM_AW'(ROM_BASE);
        end else if (run) begin
            if (unit_stb) begin
                wait_q <= '0;
                addr_q <= addr_q + (strap.wide ? ROM_AW'(2) : ROM_AW'(1));
            end else begin
                wait_q <= wait_q + WCW'(1);
            end
        end
    end

endmodule

// File: rtl/bootcopy_packer.sv
module bootcopy_packer
    import bootcopy_pkg::*;
#(
    parameter int unsigned WORDS = 256,
    localparam int unsigned IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          unit_stb,
    input  logic [15:0]   unit_data,
    input  strap_t        strap,
    output logic          ram_we,
    output logic [IW-1:0] ram_idx,
    output logic [31:0]   ram_wdata,
    output logic          last_stb
);
    logic [1:0]    lane_q;
    logic [31:0]   acc_q;
    logic [IW-1:0] cnt_q;
    logic          lane_full;
    logic [31:0]   merged;

    assign lane_full = strap.wide ? (lane_q == 2'd1) : (lane_q == 2'd3);
    assign merged    = lane_insert(acc_q, unit_data, lane_q, strap);
    assign last_stb  = unit_stb && lane_full && (cnt_q == IW'(WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q    <= '0;
            acc_q     <= '0;
            cnt_q     <= '0;
            ram_we    <= 1'b0;
            ram_idx   <= '0;
            ram_wdata <= '0;
        end else begin
            ram_we <= 1'b0;
            if (unit_stb) begin
                if (lane_full) begin
                    ram_we    <= 1'b1;
                    ram_wdata <= merged;
                    ram_idx   <= cnt_q;
                    cnt_q     <= cnt_q + IW'(1);
                    lane_q    <= '0;
                    acc_q     <= '0;
                end else begin
                    acc_q  <= merged;
                    lane_q <= lane_q + 2'd1;
                end
            end
        end
    end

endmodule

// File: rtl/bootcopy_engine.sv
module bootcopy_engine
    import bootcopy_pkg::*;
#(
    parameter int unsigned ROM_AW   = 20,
    parameter int unsigned ROM_BASE = 0,
    parameter int unsigned WAIT_CYC = 2,
    parameter int unsigned WORDS    = 256,
    localparam int unsigned IW      = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_rom16,
    input  logic              strap_big,
    output logic              rom_cs,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [15:0]       rom_data,
    output logic              ram_we,
    output logic [IW-1:0]     ram_idx,
    output logic [31:0]       ram_wdata,
    output logic              cpu_stall,
    output logic              boot_done
);
    phase_e phase_q;
    strap_t strap_q;
    logic   unit_stb;
    logic   last_stb;

    // straps follow the pins only while reset is held
    always_ff @(posedge clk) begin
        if (rst) begin
            strap_q <= '{wide: strap_rom16, big: strap_big};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE:  phase_q <= PH_COPY;
                PH_COPY:  if (last_stb) phase_q <= PH_FLUSH;
                PH_FLUSH: phase_q <= PH_DONE;
                default:  phase_q <= PH_DONE;
            endcase
        end
    end

    assign cpu_stall = (phase_q != PH_DONE);
    assign boot_done = (phase_q == PH_DONE);

    bootcopy_rom_seq #(
        .ROM_AW   (ROM_AW),
        .ROM_BASE (ROM_BASE),
        .WAIT_CYC (WAIT_CYC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .run      (phase_q == PH_COPY),
        .strap    (strap_q),
        .rom_cs   (rom_cs),
        .rom_addr (rom_addr),
        .unit_stb (unit_stb)
    );

    bootcopy_packer #(
        .WORDS (WORDS)
    ) u_pack (
        .clk       (clk),
        .rst       (rst),
        .unit_stb  (unit_stb),
        .unit_data (rom_data),
        .strap     (strap_q),
        .ram_we    (ram_we),
        .ram_idx   (ram_idx),
        .ram_wdata (ram_wdata),
        .last_stb  (last_stb)
    );

endmodule

// File: rtl/bootcopy_chk.sv
module bootcopy_chk #(
    parameter int unsigned ROM_AW = 20,
    parameter int unsigned WORDS  = 256,
    localparam int unsigned IW    = $clog2(WORDS)
) (
    input logic              clk,
    input logic              rst,
    input logic              rom_cs,
    input logic [ROM_AW-1:0] rom_addr,
    input logic              ram_we,
    input logic [IW-1:0]     ram_idx,
    input logic              cpu_stall,
    input logic              boot_done
);
    logic [IW:0] wr_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) wr_cnt_q <= '0;
        else if (ram_we) wr_cnt_q <= wr_cnt_q + (IW+1)'(1);
    end

    // R3
    idx_order_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (ram_idx == wr_cnt_q[IW-1:0]) && (wr_cnt_q < (IW+1)'(WORDS)));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rom_cs && $past(rom_cs)) |->
            (rom_addr == $past(rom_addr)) ||
            (rom_addr == $past(rom_addr) + ROM_AW'(1)) ||
            (rom_addr == $past(rom_addr) + ROM_AW'(2)));

    // R10
    stall_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> cpu_stall);

    // R10
    release_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(boot_done) |-> ($past(ram_we) && ($past(ram_idx) == IW'(WORDS - 1))));

    // R11
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        boot_done |=> boot_done);

    // R11
    quiet_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        boot_done |-> (!rom_cs && !ram_we));

endmodule

bind bootcopy_engine bootcopy_chk #(
    .ROM_AW (ROM_AW),
    .WORDS  (WORDS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rom_cs    (rom_cs),
    .rom_addr  (rom_addr),
    .ram_we    (ram_we),
    .ram_idx   (ram_idx),
    .cpu_stall (cpu_stall),
    .boot_done (boot_done)
);

// File: tb/tb_bootcopy_engine.sv
`timescale 1ns/1ps
module tb_bootcopy_engine;
    localparam int unsigned ROM_AW   = 20;
    localparam int unsigned ROM_BASE = 'h4000;
    localparam int unsigned WAIT_CYC = 3;
    localparam int unsigned WORDS    = 256;
    localparam int unsigned IW       = $clog2(WORDS);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              strap_rom16 = 1'b0;
    logic              strap_big = 1'b0;
    logic              rom_cs;
    logic [ROM_AW-1:0] rom_addr;
    logic [15:0]       rom_data;
    logic              ram_we;
    logic [IW-1:0]     ram_idx;
    logic [31:0]       ram_wdata;
    logic              cpu_stall;
    logic              boot_done;

    always #2.5 clk = ~clk;

    int total_cnt = 0;
    int fail_cnt  = 0;
    bit finished  = 0;

    logic              tb_wide = 1'b0;
    string             cur_tag = "R5";
    logic [39:0]       exp_q[$];
    logic [ROM_AW-1:0] exp_a;
    int                dwell;

    function automatic logic [7:0] b_of(input logic [ROM_AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [15:0] h_of(input logic [ROM_AW-1:0] a);
        return {~b_of(a), b_of(a) ^ 8'h33};
    endfunction

    assign rom_data = tb_wide ? h_of(rom_addr) : {8'hC3, b_of(rom_addr)};

    bootcopy_engine #(
        .ROM_AW(ROM_AW), .ROM_BASE(ROM_BASE), .WAIT_CYC(WAIT_CYC), .WORDS(WORDS)
    ) dut (
        .clk(clk), .rst(rst), .strap_rom16(strap_rom16), .strap_big(strap_big),
        .rom_cs(rom_cs), .rom_addr(rom_addr), .rom_data(rom_data),
        .ram_we(ram_we), .ram_idx(ram_idx), .ram_wdata(ram_wdata),
        .cpu_stall(cpu_stall), .boot_done(boot_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total_cnt++;
        if (!ok) begin
            fail_cnt++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // driver: expected words of one run into the scoreboard queue
    task automatic push_expected(input logic wide, input logic big);
        for (int i = 0; i < int'(WORDS); i++) begin
            logic [ROM_AW-1:0] a0;
            logic [31:0] w;
            a0 = ROM_AW'(ROM_BASE + 4 * i);
            if (!wide && !big)
                w = {b_of(a0 + 3), b_of(a0 + 2), b_of(a0 + 1), b_of(a0)};
            else if (!wide && big)
                w = {b_of(a0), b_of(a0 + 1), b_of(a0 + 2), b_of(a0 + 3)};
            else if (!big)
                w = {h_of(a0 + 2), h_of(a0)};
            else
                w = {h_of(a0), h_of(a0 + 2)};
            exp_q.push_back({IW'(i), w});
        end
    endtask

    // monitor: scoreboard pop on writes, address walk on ROM reads
    always @(negedge clk) begin
        if (!rst && ram_we) begin
            if (exp_q.size() == 0) begin
                chk(0, "R11", "write with nothing expected", {56'd0, ram_idx}, 64'd0);
            end else begin
                logic [39:0] e;
                e = exp_q.pop_front();
                chk(ram_idx == e[39:32], "R3", "word index", {56'd0, ram_idx}, {56'd0, e[39:32]});
                chk(ram_wdata == e[31:0], cur_tag, "packed word", {32'd0, ram_wdata}, {32'd0, e[31:0]});
            end
        end
        if (!rst && rom_cs) begin
            chk(rom_addr == exp_a, "R4", "rom address", {44'd0, rom_addr}, {44'd0, exp_a});
            dwell++;
            if (dwell == int'(WAIT_CYC)) begin
                dwell = 0;
                exp_a = exp_a + (tb_wide ? ROM_AW'(2) : ROM_AW'(1));
            end
        end
    end

    task automatic run_case(input logic wide, input logic big, input string tag,
                            input bit flip);
        int units;
        int t_done;
        units  = int'(WORDS) * (wide ? 2 : 4);
        t_done = units * int'(WAIT_CYC) + 2;
        @(negedge clk);
        rst = 1'b1;
        strap_rom16 = wide;
        strap_big   = big;
        tb_wide     = wide;
        cur_tag     = tag;
        repeat (3) @(negedge clk);
        // R2 reset state
        chk(cpu_stall == 1'b1 && boot_done == 1'b0 && rom_cs == 1'b0 && ram_we == 1'b0,
            "R2", "reset outputs {stall,done,cs,we}",
            {60'd0, cpu_stall, boot_done, rom_cs, ram_we}, 64'h8);
        exp_q.delete();
        push_expected(wide, big);
        exp_a = ROM_AW'(ROM_BASE);
        dwell = 0;
        rst = 1'b0;
        for (int k = 1; k <= t_done + 40; k++) begin
            @(negedge clk);
            if (k == 1)
                chk(rom_cs == 1'b1 && rom_addr == ROM_AW'(ROM_BASE), "R1",
                    "auto start {cs,addr}", {43'd0, rom_cs, rom_addr},
                    {43'd0, 1'b1, ROM_AW'(ROM_BASE)});
            if (flip && k == 100) begin
                // R9: straps change after release
                strap_rom16 = ~wide;
                strap_big   = ~big;
            end
            if (k == t_done - 1)
                chk(cpu_stall == 1'b1 && boot_done == 1'b0, "R10", "still stalled {stall,done}",
                    {62'd0, cpu_stall, boot_done}, 64'h2);
            if (k == t_done)
                chk(cpu_stall == 1'b0 && boot_done == 1'b1, "R10", "release {stall,done}",
                    {62'd0, cpu_stall, boot_done}, 64'h1);
            if (k > t_done)
                chk(boot_done == 1'b1 && rom_cs == 1'b0, "R11", "done held, no reads {done,cs}",
                    {62'd0, boot_done, rom_cs}, 64'h2);
        end
        chk(exp_q.size() == 0, flip ? "R9" : "R3", "words left unwritten",
            64'(exp_q.size()), 64'd0);
    endtask

    initial begin
        run_case(1'b0, 1'b0, "R5 R8", 1'b0);
        run_case(1'b0, 1'b1, "R6 R9", 1'b1);
        run_case(1'b1, 1'b0, "R7", 1'b0);
        run_case(1'b1, 1'b1, "R7 R9", 1'b1);
        finished = 1;
        $display("%0d/%0d checks passed", total_cnt - fail_cnt, total_cnt);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total_cnt++;
            fail_cnt++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", total_cnt - fail_cnt, total_cnt);
            $finish;
        end
    end

endmodule